// File: doc/BRIEF.md
# PWM Action Qualifier

This block drives a single PWM output bit from the events of a time base and its compare units. On every cycle where the time-base tick enable is high, it looks at which events are present: counter at zero, counter at period, compare A match and compare B match. Each event has its own two-bit action field. Compare A and compare B each have one field for the up-count direction and another for the down-count direction. The direction input picks which of the two applies. The block applies the action that wins and registers the result. A complete PWM channel uses two instances, one per output leg, fed by the same events.

Software can change the output in two ways. A one-time force latches a chosen action and applies it once, on the next tick, as the highest-priority event. A continuous force pins the output low or high for as long as it stays active. Its setting loads either on every tick (immediate) or only on ticks where the counter is at zero (shadowed). Compare-value shadowing stays outside this block, because compare matches arrive here as ready-made pulses.

Top module: `pwm_action_qual`

## Requirements
- R1: After reset the output is low, no one-time force is pending and the continuous force is off.
- R2: Action codes are 2'b00 no change, 2'b01 drive low, 2'b10 drive high, 2'b11 invert. A winning action takes effect on the output at the clock edge that samples tick high.
- R3: The compare A and compare B events use their up-count field when cnt_up is 1 and their down-count field when cnt_up is 0.
- R4: On a cycle with tick low, no event or force changes the output.
- R5: Among the events present on a tick, the order of priority is one-time force, compare B, compare A, period, zero. An event whose selected field is 2'b00 takes no part, so it does not block a lower-priority event.
- R6: A once_trig pulse with tick low is held pending with its once_act code. It is applied on the next tick and then cleared. A once_trig on a tick cycle is applied on that same tick.
- R7: After a one-time force has been applied, a later hardware event on a later tick overrides its level.
- R8: Continuous force codes are 2'b01 low, 2'b10 high, and 2'b00 or 2'b11 off. While the force is active it decides the output on every tick, and all events and one-time forces are ignored.
- R9: With hold_shadow 0, the continuous force setting loads on every tick and affects the output at that same tick edge. A change with tick low has no effect until the next tick.
- R10: With hold_shadow 1, the continuous force setting loads only on a tick where ev_zero is high. On any other tick the setting held before still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Time-base tick enable |
| cnt_up | input | 1 | Counter direction, 1 = counting up |
| ev_zero | input | 1 | Counter equals zero |
| ev_period | input | 1 | Counter equals period |
| ev_cmpa | input | 1 | Counter equals compare A |
| ev_cmpb | input | 1 | Counter equals compare B |
| act_zero | input | 2 | Action on zero event |
| act_period | input | 2 | Action on period event |
| act_cmpa_up | input | 2 | Action on compare A while counting up |
| act_cmpa_dn | input | 2 | Action on compare A while counting down |
| act_cmpb_up | input | 2 | Action on compare B while counting up |
| act_cmpb_dn | input | 2 | Action on compare B while counting down |
| once_trig | input | 1 | One-time software force request pulse |
| once_act | input | 2 | Action code of the one-time force |
| hold_mode | input | 2 | Continuous force setting |
| hold_shadow | input | 1 | 1 = continuous force loads only at zero |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The bench creates events that coincide and gives them opposing actions, so that each priority step shows up in the output. If the order were inverted, or if a 2'b00 field were allowed to mask the events below it, the output would come out at the wrong level. The bench also checks the direction choice: the same compare pulse must produce opposite levels depending on cnt_up. The one-time force is first requested with tick low, then consumed on a tick that carries a conflicting compare event. A design that acted on it at once, dropped it, or kept it past its tick would show a level that is wrong or that lingers. For the continuous force, the bench changes the setting between ticks and on ticks without a zero event while in shadow mode. A design with the wrong load point would pin or release the output one tick too early.

// File: rtl/aq_pkg.sv
package aq_pkg;

    localparam int ACT_W   = 2;
    localparam int NUM_SRC = 5;

    // Source slots, index 0 is the highest priority
    localparam int SRC_ONCE   = 0;
    localparam int SRC_CMPB   = 1;
    localparam int SRC_CMPA   = 2;
    localparam int SRC_PERIOD = 3;
    localparam int SRC_ZERO   = 4;

    typedef enum logic [ACT_W-1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } aq_act_e;

    typedef enum logic [ACT_W-1:0] {
        HOLD_OFF   = 2'b00,
        HOLD_LOW   = 2'b01,
        HOLD_HIGH  = 2'b10,
        HOLD_OFF_B = 2'b11
    } aq_hold_e;

    typedef struct packed {
        logic             pend;
        logic [ACT_W-1:0] pend_act;
        logic [ACT_W-1:0] hold;
    } aq_frc_t;

    typedef struct packed {
        logic out;
    } aq_out_t;

    function automatic logic aq_apply(input logic [ACT_W-1:0] act, input logic cur);
        logic r;
        case (aq_act_e'(act))
            ACT_LOW:    r = 1'b0;
            ACT_HIGH:   r = 1'b1;
            ACT_TOGGLE: r = ~cur;
            default:    r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/aq_event_arb.sv
module aq_event_arb
    import aq_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int AW    = ACT_W
) (
    input  logic [N_SRC-1:0]         src_hit,
    input  logic [N_SRC-1:0][AW-1:0] src_act,
    output logic                     win_valid,
    output logic [AW-1:0]            win_act
);

    logic [N_SRC-1:0] live;

    // A source competes only if it fired and its action is not "no change"
    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_live
            assign live[g] = src_hit[g] && (src_act[g] != '0);
        end
    endgenerate

    // Walk from lowest to highest priority so the highest live slot wins
    always_comb begin
        win_valid = 1'b0;
        win_act   = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (live[i]) begin
                win_valid = 1'b1;
                win_act   = src_act[i];
            end
        end
    end

endmodule

// File: rtl/aq_sw_force.sv
module aq_sw_force
    import aq_pkg::*;
#(
    parameter int AW = ACT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          ev_zero,
    input  logic          once_trig,
    input  logic [AW-1:0] once_act,
    input  logic [AW-1:0] hold_mode,
    input  logic          hold_shadow,
    output logic          once_valid,
    output logic [AW-1:0] once_act_now,
    output logic          force_on,
    output logic          force_lvl
);

    aq_frc_t frc_d, frc_q;
    logic          hold_load;
    logic [AW-1:0] hold_now;

    always_comb begin
        frc_d     = frc_q;
        hold_load = tick && (!hold_shadow || ev_zero);
        hold_now  = hold_load ? hold_mode : frc_q.hold;
        frc_d.hold = hold_now;

        once_valid   = frc_q.pend || once_trig;
        once_act_now = once_trig ? once_act : frc_q.pend_act;

        if (tick) begin
            frc_d.pend = 1'b0;
        end else if (once_trig) begin
            frc_d.pend     = 1'b1;
            frc_d.pend_act = once_act;
        end

        force_on  = (aq_hold_e'(hold_now) == HOLD_LOW) || (aq_hold_e'(hold_now) == HOLD_HIGH);
        force_lvl = (aq_hold_e'(hold_now) == HOLD_HIGH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frc_q <= '{pend: 1'b0, pend_act: ACT_NONE, hold: HOLD_OFF};
        end else begin
            frc_q <= frc_d;
        end
    end

endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
    import aq_pkg::*;
#(
    parameter logic RESET_LEVEL = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cnt_up,
    input  logic       ev_zero,
    input  logic       ev_period,
    input  logic       ev_cmpa,
    input  logic       ev_cmpb,
    input  logic [1:0] act_zero,
    input  logic [1:0] act_period,
    input  logic [1:0] act_cmpa_up,
    input  logic [1:0] act_cmpa_dn,
    input  logic [1:0] act_cmpb_up,
    input  logic [1:0] act_cmpb_dn,
    input  logic       once_trig,
    input  logic [1:0] once_act,
    input  logic [1:0] hold_mode,
    input  logic       hold_shadow,
    output logic       pwm_out
);

    logic [NUM_SRC-1:0]            src_hit;
    logic [NUM_SRC-1:0][ACT_W-1:0] src_act;
    logic                          once_valid;
    logic [ACT_W-1:0]              once_act_now;
    logic                          force_on;
    logic                          force_lvl;
    logic                          win_valid;
    logic [ACT_W-1:0]              win_act;

    aq_out_t out_d, out_q;

    aq_sw_force #(.AW(ACT_W)) u_force (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .ev_zero      (ev_zero),
        .once_trig    (once_trig),
        .once_act     (once_act),
        .hold_mode    (hold_mode),
        .hold_shadow  (hold_shadow),
        .once_valid   (once_valid),
        .once_act_now (once_act_now),
        .force_on     (force_on),
        .force_lvl    (force_lvl)
    );

    // Source vector in priority order, compare fields picked by direction
    always_comb begin
        src_hit             = '0;
        src_act             = '0;
        src_hit[SRC_ONCE]   = once_valid;
        src_act[SRC_ONCE]   = once_act_now;
        src_hit[SRC_CMPB]   = ev_cmpb;
        src_act[SRC_CMPB]   = cnt_up ? act_cmpb_up : act_cmpb_dn;
        src_hit[SRC_CMPA]   = ev_cmpa;
        src_act[SRC_CMPA]   = cnt_up ? act_cmpa_up : act_cmpa_dn;
        src_hit[SRC_PERIOD] = ev_period;
        src_act[SRC_PERIOD] = act_period;
        src_hit[SRC_ZERO]   = ev_zero;
        src_act[SRC_ZERO]   = act_zero;
    end

    aq_event_arb #(.N_SRC(NUM_SRC), .AW(ACT_W)) u_arb (
        .src_hit   (src_hit),
        .src_act   (src_act),
        .win_valid (win_valid),
        .win_act   (win_act)
    );

    always_comb begin
        out_d = out_q;
        if (tick) begin
            if (force_on) begin
                out_d.out = force_lvl;
            end else if (win_valid) begin
                out_d.out = aq_apply(win_act, out_q.out);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.out <= RESET_LEVEL;
        end else begin
            out_q <= out_d;
        end
    end

    assign pwm_out = out_q.out;

endmodule

// File: rtl/aq_chk.sv
module aq_chk #(
    parameter logic RESET_LEVEL = 1'b0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic [1:0] hold_mode,
    input logic       hold_shadow,
    input logic       pwm_out
);

    // R1
    reset_level_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (pwm_out == RESET_LEVEL));

    // R4
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pwm_out));

    // R8 R9
    hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !hold_shadow && hold_mode == 2'b01) |=> !pwm_out);

    // R8 R9
    hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !hold_shadow && hold_mode == 2'b10) |=> pwm_out);

endmodule

bind pwm_action_qual aq_chk #(.RESET_LEVEL(RESET_LEVEL)) u_aq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .hold_mode   (hold_mode),
    .hold_shadow (hold_shadow),
    .pwm_out     (pwm_out)
);

// File: tb/tb_pwm_action_qual.sv
`timescale 1ns/1ps
module tb_pwm_action_qual;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, cnt_up = 1'b0;
    logic       ev_zero = 1'b0, ev_period = 1'b0, ev_cmpa = 1'b0, ev_cmpb = 1'b0;
    logic [1:0] act_zero = 2'b00, act_period = 2'b00;
    logic [1:0] act_cmpa_up = 2'b00, act_cmpa_dn = 2'b00;
    logic [1:0] act_cmpb_up = 2'b00, act_cmpb_dn = 2'b00;
    logic       once_trig = 1'b0;
    logic [1:0] once_act = 2'b00;
    logic [1:0] hold_mode = 2'b00;
    logic       hold_shadow = 1'b0;
    logic       pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;
    item_t sb_q[$];

    // Reference model state
    logic       m_out = 1'b0;
    logic       m_pend = 1'b0;
    logic [1:0] m_pact = 2'b00;
    logic [1:0] m_hold = 2'b00;

    always #10 clk = ~clk;

    pwm_action_qual dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_up(cnt_up),
        .ev_zero(ev_zero), .ev_period(ev_period), .ev_cmpa(ev_cmpa), .ev_cmpb(ev_cmpb),
        .act_zero(act_zero), .act_period(act_period),
        .act_cmpa_up(act_cmpa_up), .act_cmpa_dn(act_cmpa_dn),
        .act_cmpb_up(act_cmpb_up), .act_cmpb_dn(act_cmpb_dn),
        .once_trig(once_trig), .once_act(once_act),
        .hold_mode(hold_mode), .hold_shadow(hold_shadow),
        .pwm_out(pwm_out)
    );

    function automatic logic apply(input logic [1:0] a, input logic cur);
        case (a)
            2'b01:   return 1'b0;
            2'b10:   return 1'b1;
            2'b11:   return ~cur;
            default: return cur;
        endcase
    endfunction

    task automatic model();
        logic [1:0] nh;
        logic [1:0] w;
        logic       wv;
        logic [1:0] oa;
        logic [1:0] ca;
        logic [1:0] cb;
        nh = (tick && (!hold_shadow || ev_zero)) ? hold_mode : m_hold;
        oa = once_trig ? once_act : m_pact;
        ca = cnt_up ? act_cmpa_up : act_cmpa_dn;
        cb = cnt_up ? act_cmpb_up : act_cmpb_dn;
        if (tick) begin
            if (nh == 2'b01) m_out = 1'b0;
            else if (nh == 2'b10) m_out = 1'b1;
            else begin
                wv = 1'b1;
                w  = 2'b00;
                if ((m_pend || once_trig) && oa != 2'b00) w = oa;
                else if (ev_cmpb && cb != 2'b00)          w = cb;
                else if (ev_cmpa && ca != 2'b00)          w = ca;
                else if (ev_period && act_period != 2'b00) w = act_period;
                else if (ev_zero && act_zero != 2'b00)    w = act_zero;
                else wv = 1'b0;
                if (wv) m_out = apply(w, m_out);
            end
            m_pend = 1'b0;
        end else if (once_trig) begin
            m_pend = 1'b1;
            m_pact = once_act;
        end
        m_hold = nh;
    endtask

    // Driver: inputs already set at a falling edge; one rising edge, then predict
    task automatic cycle(input string tag);
        item_t it;
        @(posedge clk);
        model();
        it.exp = m_out;
        it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        tick = 1'b0; ev_zero = 1'b0; ev_period = 1'b0;
        ev_cmpa = 1'b0; ev_cmpb = 1'b0; once_trig = 1'b0;
    endtask

    // Monitor: compares at falling edges, away from the active edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (pwm_out !== it.exp) begin
                errors++;
                $display("FAIL %s: pwm_out=%b expected=%b", it.tag, pwm_out, it.exp);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (pwm_out !== 1'b0) begin
            errors++;
            $display("FAIL R1: pwm_out=%b expected=0", pwm_out);
        end

        // R2 R3: compare A up sets, down clears
        act_cmpa_up = 2'b10; act_cmpa_dn = 2'b01;
        tick = 1; cnt_up = 1; ev_cmpa = 1; cycle("R2 R3 cmpa up high");
        tick = 1; cnt_up = 0; ev_cmpa = 1; cycle("R3 cmpa down low");
        // R4: no tick, events ignored
        cnt_up = 1; ev_cmpa = 1; ev_zero = 1; cycle("R4 idle no change");
        // R2: toggle on zero
        act_zero = 2'b11;
        tick = 1; ev_zero = 1; cycle("R2 zero toggle to 1");
        tick = 1; ev_zero = 1; cycle("R2 zero toggle to 0");
        // R5: compare B beats compare A
        tick = 1; ev_zero = 1; cycle("R2 toggle up");
        act_cmpb_up = 2'b01;
        tick = 1; cnt_up = 1; ev_cmpa = 1; ev_cmpb = 1; cycle("R5 cmpb over cmpa");
        // R5: compare A beats period
        act_period = 2'b10;
        tick = 1; cnt_up = 0; ev_cmpa = 1; ev_period = 1; cycle("R5 cmpa over period");
        // R5: period beats zero
        tick = 1; ev_period = 1; cycle("R2 period high");
        tick = 1; ev_period = 1; ev_zero = 1; cycle("R5 period over zero");
        // R5: disabled compare B does not block compare A
        act_cmpb_dn = 2'b00;
        tick = 1; cnt_up = 0; ev_cmpb = 1; ev_cmpa = 1; cycle("R5 null field passes");
        // R6: one-time force pending, applied on next tick over compare B
        once_act = 2'b10; once_trig = 1; cycle("R6 pending not applied");
        tick = 1; cnt_up = 1; ev_cmpb = 1; cycle("R6 once over cmpb");
        tick = 1; cycle("R6 cleared no repeat");
        tick = 1; cnt_up = 1; ev_cmpb = 1; cycle("R7 hw overrides once");
        // R6: trigger on tick cycle
        once_act = 2'b11; once_trig = 1; tick = 1; cycle("R6 same tick toggle");
        tick = 1; cycle("R6 not reapplied");
        // R8 R9: immediate continuous force
        hold_shadow = 0; hold_mode = 2'b01; cycle("R9 waits for tick");
        tick = 1; ev_period = 1; cycle("R8 R9 hold low over period");
        once_act = 2'b10; once_trig = 1; tick = 1; cycle("R8 hold low over once");
        hold_mode = 2'b10; tick = 1; cycle("R8 hold high");
        hold_mode = 2'b11; tick = 1; cnt_up = 0; ev_cmpa = 1; cycle("R8 code 11 off");
        // R10: shadowed continuous force
        hold_shadow = 1; hold_mode = 2'b10;
        tick = 1; cnt_up = 0; ev_cmpa = 1; cycle("R10 not loaded off zero");
        tick = 1; ev_zero = 1; cycle("R10 loaded at zero");
        hold_mode = 2'b00; tick = 1; cnt_up = 0; ev_cmpa = 1; cycle("R10 old hold kept");
        tick = 1; ev_zero = 1; cycle("R10 released at zero toggle");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule